// File: doc/BRIEF.md
# Firmware-Memory Write Target

This block sits on a low-pin-count host bus as a target. It watches a 4-bit multiplexed address/data bus (`lad_i`) and an active-low framing strobe (`frame_ni`). It picks out firmware-memory write transactions that carry its own strap ID. From each one it collects a 28-bit address, a size code and one, two or four data bytes. All bus fields are sampled on the rising edge of the bus clock.

Once the data phase ends, the host hands the bus over in two turnaround clocks. The block then drives a ready-sync nibble of zero, and in that same clock it presents a write request to the local memory side. The request carries the address, a byte count and a little-endian 32-bit data word, and lasts one clock. Next the block drives all ones for one clock and releases the bus. The bus output enable (`lad_oe_o`) is high only in those two clocks.

The block returns to idle when a transaction is not for it or carries an unsupported size. It also returns to idle when a framing strobe interrupts a transaction part way. In idle it never drives the bus, and it waits there for the next framing strobe.

Top module: `lpc_fwm_wr_target`

## Requirements
- R1: A transaction starts only while `frame_ni` is low. The start nibble that counts is the one sampled in the last clock before `frame_ni` returns high. Only the value 4'b1110 selects a write; any other value leaves the block idle.
- R2: The first nibble after the start nibble is the ID select. If it differs from `id_i`, no request is issued and `lad_oe_o` stays low for the rest of the transaction.
- R3: The next seven nibbles form `wr_addr_o[27:0]`, most significant nibble first.
- R4: The size nibble sets the byte count: 4'b0000 gives `wr_len_o`=1, 4'b0001 gives 2 and 4'b0010 gives 4. Any other size value aborts the transaction silently, with no request and no bus drive.
- R5: The data phase lasts two clocks per byte. Each byte arrives low nibble first, and byte k lands in `wr_data_o[8k+7:8k]`. Bytes that were not transferred read as zero.
- R6: After the last data nibble come two clocks in which the target does not drive. In the third clock the target drives 4'b0000 with `lad_oe_o` high. In the fourth it drives 4'b1111 with `lad_oe_o` high. In the fifth `lad_oe_o` is low again.
- R7: `wr_req_o` is high for exactly one clock, which is the ready-sync clock. `wr_addr_o`, `wr_len_o` and `wr_data_o` are valid in that clock.
- R8: If `frame_ni` is low at any point inside a transaction, the transaction is dropped without a request, and start-field detection begins again.
- R9: After reset `wr_req_o` and `lad_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; fields sampled on rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_ni | input | 1 | Active-low transaction framing strobe |
| lad_i | input | 4 | Bus nibble as seen at the pads |
| id_i | input | 4 | Strap ID of this target |
| lad_o | output | 4 | Nibble driven by the target |
| lad_oe_o | output | 1 | Tri-state enable for `lad_o` |
| wr_req_o | output | 1 | One-clock write request to memory side |
| wr_addr_o | output | 28 | Write address |
| wr_len_o | output | 3 | Byte count: 1, 2 or 4 |
| wr_data_o | output | 32 | Write data, byte 0 in bits 7:0 |

## Verification
The bench sweeps the ID-select nibble over all sixteen values with one strap ID, so only the matching value may give a request. It sweeps the size nibble over three legal codes and one illegal one, each with several addresses and data words. These runs separate correct byte placement, correct masking of untransferred bytes and correct nibble order from a transposed or shifted capture. Start fields repeated with the real start value placed first or last check that only the final start nibble counts. Aborts are injected at every position from the ID-select clock through the second turnaround clock, which confirms that an interrupted write never produces a request or a bus drive.

// File: rtl/lpc_fwm_pkg.sv
package lpc_fwm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_SIZE, S_DATA, S_TAR0, S_TAR1, S_SYNC, S_RTAR
  } fwm_state_e;
endpackage

// File: rtl/lpc_fwm_ctrl.sv
module lpc_fwm_ctrl
  import lpc_fwm_pkg::*;
#(
  parameter int         ADDR_NIBBLES = 7,
  parameter int         MAX_SIZE     = 2,
  parameter logic [3:0] START_CODE   = 4'hE,
  parameter int         CNT_W        = 3,
  parameter int         SIZE_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic [3:0]       lad_i,
  input  logic [3:0]       id_i,
  output fwm_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             size_ok_o
);
  fwm_state_e        state_q;
  logic [3:0]        start_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SIZE_W-1:0] msize_q;
  logic [CNT_W-1:0]  data_last;

  assign data_last = CNT_W'((32'd2 << msize_q) - 32'd1);
  assign size_ok_o = frame_ni && (state_q == S_SIZE) && (lad_i <= 4'(MAX_SIZE));
  assign state_o   = state_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      start_q <= '0;
      cnt_q   <= '0;
      msize_q <= '0;
    end else if (!frame_ni) begin
      // newest start nibble wins; also aborts anything in flight
      state_q <= S_START;
      start_q <= lad_i;
    end else begin
      unique case (state_q)
        S_START: begin
          cnt_q   <= '0;
          state_q <= (start_q == START_CODE && lad_i == id_i) ? S_ADDR : S_IDLE;
        end
        S_ADDR: begin
          if (cnt_q == CNT_W'(ADDR_NIBBLES - 1)) state_q <= S_SIZE;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_SIZE: begin
          cnt_q <= '0;
          if (size_ok_o) begin
            msize_q <= lad_i[SIZE_W-1:0];
            state_q <= S_DATA;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_DATA: begin
          if (cnt_q == data_last) state_q <= S_TAR0;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_TAR0:  state_q <= S_TAR1;
        S_TAR1:  state_q <= S_SYNC;
        S_SYNC:  state_q <= S_RTAR;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R6
  sync_after_tar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SYNC) |-> ($past(state_q) == S_TAR1 && $past(frame_ni)));
  // R8
  abort_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |=> (state_q == S_START && start_q == $past(lad_i)));
endmodule

// File: rtl/lpc_fwm_capture.sv
module lpc_fwm_capture
  import lpc_fwm_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3,
  parameter int SIZE_W = 2,
  parameter int LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        lad_i,
  input  fwm_state_e        state_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              size_ok_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] data_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      len_q  <= '0;
      data_q <= '0;
    end else if (frame_ni) begin
      if (state_i == S_ADDR) addr_q <= {addr_q[ADDR_W-5:0], lad_i};
      if (size_ok_i) begin
        len_q  <= LEN_W'(1) << lad_i[SIZE_W-1:0];
        data_q <= '0;
      end
      // nibble k of the data phase is bit field [4k+3:4k]
      if (state_i == S_DATA) data_q[{cnt_i, 2'b00} +: 4] <= lad_i;
    end
  end

  assign addr_o = addr_q;
  assign len_o  = len_q;
  assign data_o = data_q;

  // R3
  addr_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ni && state_i == S_ADDR) |=> (addr_q[3:0] == $past(lad_i)));
endmodule

// File: rtl/lpc_fwm_wr_target.sv
module lpc_fwm_wr_target
  import lpc_fwm_pkg::*;
#(
  parameter int         ADDR_NIBBLES = 7,
  parameter int         MAX_SIZE     = 2,
  parameter logic [3:0] START_CODE   = 4'hE,
  localparam int ADDR_W  = 4 * ADDR_NIBBLES,
  localparam int DATA_W  = 8 << MAX_SIZE,
  localparam int MAX_NIB = (ADDR_NIBBLES > (2 << MAX_SIZE)) ? ADDR_NIBBLES : (2 << MAX_SIZE),
  localparam int CNT_W   = $clog2(MAX_NIB),
  localparam int SIZE_W  = (MAX_SIZE < 1) ? 1 : $clog2(MAX_SIZE + 1),
  localparam int LEN_W   = $clog2((1 << MAX_SIZE) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        lad_i,
  input  logic [3:0]        id_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LEN_W-1:0]  wr_len_o,
  output logic [DATA_W-1:0] wr_data_o
);
  fwm_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             size_ok;

  lpc_fwm_ctrl #(
    .ADDR_NIBBLES(ADDR_NIBBLES), .MAX_SIZE(MAX_SIZE), .START_CODE(START_CODE),
    .CNT_W(CNT_W), .SIZE_W(SIZE_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .frame_ni, .lad_i, .id_i,
    .state_o(state), .cnt_o(cnt), .size_ok_o(size_ok)
  );

  lpc_fwm_capture #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W), .LEN_W(LEN_W)
  ) u_cap (
    .clk_i, .rst_ni, .frame_ni, .lad_i,
    .state_i(state), .cnt_i(cnt), .size_ok_i(size_ok),
    .addr_o(wr_addr_o), .len_o(wr_len_o), .data_o(wr_data_o)
  );

  assign wr_req_o = (state == S_SYNC);
  assign lad_oe_o = (state == S_SYNC) || (state == S_RTAR);
  assign lad_o    = (state == S_RTAR) ? 4'hF : 4'h0;

  // R7
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> !wr_req_o);
  // R6
  drive_starts_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |-> (lad_o == 4'h0 && wr_req_o));
  // R6
  sync_then_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && frame_ni) |=> (lad_oe_o && lad_o == 4'hF));
  // R4
  len_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> $onehot(wr_len_o));
  // R8
  no_drive_after_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |=> !lad_oe_o);
endmodule

// File: tb/lpc_fwm_wr_target_test.sv
module lpc_fwm_wr_target_test;
  localparam logic [3:0] MY_ID = 4'h5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_ni = 1'b1;
  logic [3:0]  lad_i = 4'hF;
  logic [3:0]  id_i = MY_ID;
  logic [3:0]  lad_o;
  logic        lad_oe_o, wr_req_o;
  logic [27:0] wr_addr_o;
  logic [2:0]  wr_len_o;
  logic [31:0] wr_data_o;

  int vectors = 0, errors = 0, req_seen = 0, oe_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpc_fwm_wr_target uut (
    .clk_i(clk), .rst_ni, .frame_ni, .lad_i, .id_i,
    .lad_o, .lad_oe_o, .wr_req_o, .wr_addr_o, .wr_len_o, .wr_data_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic [3:0] n);
    @(negedge clk);
    if (wr_req_o) req_seen++;
    if (lad_oe_o) oe_seen++;
    frame_ni = f;
    lad_i    = n;
  endtask

  // prefix: earlier start nibble (used when nstart==2); abort_at <0 means none
  task automatic xfer(input int nstart, input logic [3:0] prefix, input logic [3:0] start,
                      input logic [3:0] idsel, input logic [27:0] addr, input logic [3:0] sz,
                      input logic [31:0] data, input int abort_at);
    logic [3:0]  seq [20];
    int          n, ndat;
    bit          hit;
    logic [31:0] mask;
    req_seen = 0;
    oe_seen  = 0;
    ndat = (sz <= 4'd2) ? (2 << sz) : 2;
    seq[0] = idsel;
    for (int i = 0; i < 7; i++) seq[1+i] = addr[27-4*i -: 4];
    seq[8] = sz;
    for (int k = 0; k < ndat; k++) seq[9+k] = data[4*k +: 4];
    seq[9+ndat]  = 4'hF;
    seq[10+ndat] = 4'hF;
    n = 11 + ndat;
    hit = (start == 4'hE) && (idsel == MY_ID) && (sz <= 4'd2) && (abort_at < 0);
    if (nstart > 1) drive(1'b0, prefix);
    drive(1'b0, start);
    for (int p = 0; p < n; p++) begin
      if (p == abort_at) begin
        drive(1'b0, 4'h0);
        break;
      end
      drive(1'b1, seq[p]);
    end
    if (hit) begin
      mask = (sz == 4'd2) ? 32'hFFFF_FFFF : ((32'd1 << (8 << sz)) - 32'd1);
      drive(1'b1, 4'hF);
      // R7 R6 sync clock
      chk(wr_req_o === 1'b1, "R7 req in sync clock", {31'd0, wr_req_o}, 32'd1);
      chk(lad_oe_o === 1'b1 && lad_o === 4'h0, "R6 sync drives 0000", {27'd0, lad_oe_o, lad_o}, 32'h10);
      chk(wr_addr_o === addr, "R3 address", {4'd0, wr_addr_o}, {4'd0, addr});
      chk(wr_len_o === 3'(1 << sz), "R4 byte count", {29'd0, wr_len_o}, 32'(1 << sz));
      chk(wr_data_o === (data & mask), "R5 data", wr_data_o, data & mask);
      drive(1'b1, 4'hF);
      chk(lad_oe_o === 1'b1 && lad_o === 4'hF && !wr_req_o, "R6 ones after sync",
          {26'd0, wr_req_o, lad_oe_o, lad_o}, 32'h1F);
      drive(1'b1, 4'hF);
      chk(lad_oe_o === 1'b0, "R6 released", {31'd0, lad_oe_o}, 32'd0);
    end
    repeat (3) drive(1'b1, 4'hF);
    chk(req_seen == (hit ? 1 : 0), hit ? "R7 one request" : "R1 R2 R4 R8 no request",
        req_seen, hit ? 1 : 0);
    chk(oe_seen == (hit ? 2 : 0), hit ? "R6 two drive clocks" : "R2 R8 no drive",
        oe_seen, hit ? 2 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_req_o && !lad_oe_o, "R9 reset outputs", {30'd0, wr_req_o, lad_oe_o}, 32'd0);
    rst_ni = 1'b1;
    // R2 ID-select sweep
    for (int s = 0; s < 16; s++)
      xfer(1, 4'h0, 4'hE, 4'(s), 28'h0A1_B2C3 + 28'(s), 4'd0, 32'h0000_00C7 ^ 32'(s), -1);
    // R3 R4 R5 size and pattern sweep
    for (int sz = 0; sz < 4; sz++)
      for (int v = 0; v < 4; v++)
        xfer(1, 4'h0, 4'hE, MY_ID, 28'h123_4567 ^ (28'(v) * 28'h0F0_F0F1),
             4'(sz), 32'h8765_4321 ^ (32'(v) * 32'h1111_1111) ^ 32'(sz << 28), -1);
    // R1 start-field handling
    xfer(1, 4'h0, 4'hD, MY_ID, 28'h0, 4'd0, 32'h5A, -1);
    xfer(2, 4'hE, 4'hD, MY_ID, 28'h1, 4'd1, 32'h5A, -1);
    xfer(2, 4'hD, 4'hE, MY_ID, 28'hFFF_FFFE, 4'd1, 32'hBEEF, -1);
    // R8 abort at every position (idsel .. second turnaround), 4-byte size
    for (int a = 0; a < 19; a++)
      xfer(1, 4'h0, 4'hE, MY_ID, 28'h765_4321, 4'd2, 32'hDEAD_BEEF, a);
    // recovers after aborts
    xfer(1, 4'h0, 4'hE, MY_ID, 28'hABC_DEF0, 4'd2, 32'h0123_4567, -1);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule